// File: doc/BRIEF.md
# Target Write Combine Buffer Timer

This block decides when write data that an external bus master has posted into the target write buffer is sent on to the internal bus. Consecutive (sequential) write beats are gathered into one burst. A partial burst stays in the buffer until one of these events occurs:
- the burst fills;
- a non-sequential beat arrives;
- combining is switched off;
- a programmable countdown expires because the external writer has gone quiet.

The countdown is measured in bus clocks and restarts at the programmed value each time a beat is stored. Software can rewrite that value at any time. A value smaller than the running count pulls the count down at once, so the flush comes sooner. With combining disabled, every beat is handed on as its own single-beat transfer.

The storage array and the internal bus master sit outside this block. This block receives the beat strobes and the full indication. It returns a one-clock flush request, a single-beat-mode flag and the live count.

Top module: `wrCombineTimer`

## Requirements
- R1: After reset `timerValue` reads 0 and `flushReq` is low. The programmed reload value is 8 (0x08), so the first beat stored after reset loads 8.
- R2: A beat stored with `combineDisable` low and `burstFull` low loads the reload value in force before that clock edge. `timerValue` shows it one clock later. While the partial burst is held and no beat arrives, `timerValue` then drops by exactly 1 per clock.
- R3: When a partial burst is held, no beat arrives and `timerValue` is 0, `flushReq` is high for exactly the next clock. The held burst is then released: no second flush follows without new beats, and `timerValue` stays 0.
- R4: A sequential beat (`beatSeq`=1) stored during a countdown restarts the count at the reload value and produces no flush.
- R5: While a countdown runs, a write of `reloadData` with `reloadWrite`=1 whose value is strictly below the current `timerValue` sets `timerValue` to that value on the next clock. The write also becomes the new reload value.
- R6: A reload write whose value is equal to or above the current count leaves the running countdown decrementing normally. It is used from the next stored beat onward. A reload write with nothing held leaves `timerValue` at 0.
- R7: With `combineDisable`=1, `singleBeatMode` is 1 and `timerValue` stays 0. Every stored beat gives `flushReq` on the next clock. A partial burst held when `combineDisable` rises is flushed on the next clock.
- R8: A beat stored with `burstFull`=1 (and `combineDisable`=0) raises `flushReq` on the next clock, clears `timerValue` to 0 and releases the burst without waiting for the timer.
- R9: A non-sequential beat (`beatSeq`=0) stored while a partial burst is held raises `flushReq` on the next clock and starts a new countdown at the reload value. With nothing held, such a beat only starts a countdown and gives no flush.
- R10: With a reload value of 0, a stored beat shows `timerValue` 0 on the next clock and `flushReq` on the clock after that.
- R11: `burstFull` asserted without a stored beat has no effect. With nothing held and no beat stored, `flushReq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the timer counts these clocks |
| rstN | input | 1 | Active-low synchronous reset |
| beatStored | input | 1 | One write beat was placed in the buffer this clock |
| beatSeq | input | 1 | The stored beat follows on from the previous one |
| burstFull | input | 1 | With `beatStored`, this beat completes a full burst |
| reloadData | input | 8 | New countdown reload value |
| reloadWrite | input | 1 | Load `reloadData` as the reload value |
| combineDisable | input | 1 | Forward each beat alone, with no combining |
| flushReq | output | 1 | One-clock request to drain the buffered burst |
| singleBeatMode | output | 1 | Beats are being forwarded as single transfers |
| timerValue | output | 8 | Current countdown value, 0 when idle |

## Verification
The assertions assume that `beatStored`, `beatSeq`, `burstFull` and `reloadWrite` are clean, one-clock-per-event strobes sampled at the rising edge. They also assume that `burstFull` only carries meaning alongside a stored beat. The checker keeps its own copy of the reload value, taken from `reloadWrite` alone, to predict what a beat loads. The stimulus changes every input half a clock away from the edge. It never writes the reload value in the same clock as a beat, so the reload value in force is always the one written earlier.

// File: rtl/wrCombinePkg.sv
package wrCombinePkg;

  // Strobes the control sends to the counter datapath; at most one is set.
  typedef struct packed {
    logic clrCount;   // drop count to zero (burst released)
    logic loadCount;  // restart count from reload value
    logic pullDown;   // jump count down to the newly written value
    logic decCount;   // one clock elapsed with the burst held
  } cntStrobe_t;

endpackage

// File: rtl/wrCombineDatapath.sv
module wrCombineDatapath
  import wrCombinePkg::*;
#(
  parameter int TIMER_W      = 8,
  parameter int RESET_RELOAD = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  cntStrobe_t         strobe,
  input  logic [TIMER_W-1:0] reloadData,
  input  logic               reloadWrite,
  output logic [TIMER_W-1:0] countVal,
  output logic               countZero,
  output logic               newBelow
);

  localparam logic [TIMER_W-1:0] RELOAD_INIT = TIMER_W'(RESET_RELOAD);
  localparam logic [TIMER_W-1:0] ONE         = TIMER_W'(1);

  logic [TIMER_W-1:0] reloadReg;
  logic [TIMER_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= RELOAD_INIT;
    end else if (reloadWrite) begin
      reloadReg <= reloadData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.clrCount) begin
      countQ <= '0;
    end else if (strobe.loadCount) begin
      countQ <= reloadReg;
    end else if (strobe.pullDown) begin
      countQ <= reloadData;
    end else if (strobe.decCount) begin
      countQ <= countQ - ONE;
    end
  end

  assign countVal  = countQ;
  assign countZero = (countQ == '0);
  assign newBelow  = (reloadData < countQ);

endmodule

// File: rtl/wrCombineCtrl.sv
module wrCombineCtrl
  import wrCombinePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       beatStored,
  input  logic       beatSeq,
  input  logic       burstFull,
  input  logic       reloadWrite,
  input  logic       combineDisable,
  input  logic       countZero,
  input  logic       newBelow,
  output cntStrobe_t strobe,
  output logic       flushReq,
  output logic       partialHeld
);

  logic heldQ, heldNext;
  logic flushQ, flushNext;

  always_comb begin
    strobe    = '0;
    flushNext = 1'b0;
    heldNext  = heldQ;
    if (combineDisable) begin
      // single-beat mode: anything arriving or still held goes out now
      flushNext       = beatStored | heldQ;
      heldNext        = 1'b0;
      strobe.clrCount = 1'b1;
    end else if (beatStored && burstFull) begin
      flushNext       = 1'b1;
      heldNext        = 1'b0;
      strobe.clrCount = 1'b1;
    end else if (beatStored) begin
      // a break in sequence drains the old partial burst first
      flushNext        = heldQ & ~beatSeq;
      heldNext         = 1'b1;
      strobe.loadCount = 1'b1;
    end else if (heldQ) begin
      if (countZero) begin
        flushNext       = 1'b1;
        heldNext        = 1'b0;
        strobe.clrCount = 1'b1;
      end else if (reloadWrite && newBelow) begin
        strobe.pullDown = 1'b1;
      end else begin
        strobe.decCount = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldQ  <= 1'b0;
      flushQ <= 1'b0;
    end else begin
      heldQ  <= heldNext;
      flushQ <= flushNext;
    end
  end

  assign flushReq    = flushQ;
  assign partialHeld = heldQ;

endmodule

// File: rtl/wrCombineTimer.sv
module wrCombineTimer
  import wrCombinePkg::*;
#(
  parameter int TIMER_W      = 8,
  parameter int RESET_RELOAD = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               beatStored,
  input  logic               beatSeq,
  input  logic               burstFull,
  input  logic [TIMER_W-1:0] reloadData,
  input  logic               reloadWrite,
  input  logic               combineDisable,
  output logic               flushReq,
  output logic               singleBeatMode,
  output logic [TIMER_W-1:0] timerValue
);

  cntStrobe_t strobe;
  logic       countZero;
  logic       newBelow;
  logic       partialHeld;

  wrCombineCtrl uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .beatStored     (beatStored),
    .beatSeq        (beatSeq),
    .burstFull      (burstFull),
    .reloadWrite    (reloadWrite),
    .combineDisable (combineDisable),
    .countZero      (countZero),
    .newBelow       (newBelow),
    .strobe         (strobe),
    .flushReq       (flushReq),
    .partialHeld    (partialHeld)
  );

  wrCombineDatapath #(
    .TIMER_W      (TIMER_W),
    .RESET_RELOAD (RESET_RELOAD)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reloadData  (reloadData),
    .reloadWrite (reloadWrite),
    .countVal    (timerValue),
    .countZero   (countZero),
    .newBelow    (newBelow)
  );

  assign singleBeatMode = combineDisable;

endmodule

// File: rtl/wrCombineChecker.sv
module wrCombineChecker #(
  parameter int TIMER_W      = 8,
  parameter int RESET_RELOAD = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               beatStored,
  input logic               burstFull,
  input logic [TIMER_W-1:0] reloadData,
  input logic               reloadWrite,
  input logic               combineDisable,
  input logic               flushReq,
  input logic [TIMER_W-1:0] timerValue,
  input logic               partialHeld
);

  logic [TIMER_W-1:0] shadowReload;

  always_ff @(posedge clk) begin
    if (!rstN) shadowReload <= TIMER_W'(RESET_RELOAD);
    else if (reloadWrite) shadowReload <= reloadData;
  end

  AST_LOAD_ON_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    beatStored && !burstFull && !combineDisable |=> timerValue == $past(shadowReload)); // R2

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    partialHeld && !beatStored && !combineDisable && !reloadWrite && timerValue != '0
    |=> timerValue == $past(timerValue) - TIMER_W'(1)); // R2

  AST_EXPIRE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    partialHeld && !beatStored && !combineDisable && timerValue == '0
    |=> flushReq && !partialHeld); // R3

  AST_PULL_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    partialHeld && !beatStored && !combineDisable && reloadWrite && reloadData < timerValue
    |=> timerValue == $past(reloadData)); // R5

  AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    combineDisable && beatStored |=> flushReq && timerValue == '0); // R7

  AST_FULL_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    beatStored && burstFull && !combineDisable |=> flushReq && timerValue == '0); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !partialHeld && !beatStored |=> !flushReq); // R11

endmodule

bind wrCombineTimer wrCombineChecker #(
  .TIMER_W      (TIMER_W),
  .RESET_RELOAD (RESET_RELOAD)
) uChk (
  .clk            (clk),
  .rstN           (rstN),
  .beatStored     (beatStored),
  .burstFull      (burstFull),
  .reloadData     (reloadData),
  .reloadWrite    (reloadWrite),
  .combineDisable (combineDisable),
  .flushReq       (flushReq),
  .timerValue     (timerValue),
  .partialHeld    (partialHeld)
);

// File: tb/sim_wrCombineTimer.sv
module sim_wrCombineTimer;

  logic       clk = 1'b0;
  logic       rstN;
  logic       beatStored, beatSeq, burstFull, reloadWrite, combineDisable;
  logic [7:0] reloadData;
  logic       flushReq, singleBeatMode;
  logic [7:0] timerValue;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wrCombineTimer u0 (
    .clk(clk), .rstN(rstN), .beatStored(beatStored), .beatSeq(beatSeq),
    .burstFull(burstFull), .reloadData(reloadData), .reloadWrite(reloadWrite),
    .combineDisable(combineDisable), .flushReq(flushReq),
    .singleBeatMode(singleBeatMode), .timerValue(timerValue)
  );

  typedef struct packed {
    logic       beat;
    logic       seq;
    logic       full;
    logic       wr;
    logic [7:0] data;
    logic       dis;
    logic       expF;
    logic [7:0] expT;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 31;
  // beat seq full wr data dis | flush timer | requirement
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,8'd3,1'b0, 1'b0,8'd0, 4'd6},  // R6 write while idle
    '{1'b1,1'b1,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd3, 4'd2},  // R2 load
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd2, 4'd2},
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd1, 4'd2},
    '{1'b1,1'b1,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd3, 4'd4},  // R4 restart
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd2, 4'd2},
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd1, 4'd2},
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd0, 4'd2},
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b1,8'd0, 4'd3},  // R3 expiry
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd0, 4'd3},
    '{1'b1,1'b1,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd3, 4'd2},
    '{1'b0,1'b0,1'b0,1'b1,8'd1,1'b0, 1'b0,8'd1, 4'd5},  // R5 pull down
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd0, 4'd5},
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b1,8'd0, 4'd5},
    '{1'b0,1'b0,1'b0,1'b1,8'd5,1'b0, 1'b0,8'd0, 4'd6},
    '{1'b1,1'b1,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd5, 4'd6},
    '{1'b0,1'b0,1'b0,1'b1,8'd9,1'b0, 1'b0,8'd4, 4'd6},  // R6 higher value
    '{1'b1,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b1,8'd9, 4'd9},  // R9 break in sequence
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd8, 4'd9},
    '{1'b1,1'b1,1'b1,1'b0,8'd0,1'b0, 1'b1,8'd0, 4'd8},  // R8 full burst
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd0, 4'd8},
    '{1'b0,1'b0,1'b1,1'b0,8'd0,1'b0, 1'b0,8'd0, 4'd11}, // R11 full alone
    '{1'b1,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd9, 4'd9},  // R9 nothing held
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b1, 1'b1,8'd0, 4'd7},  // R7 held drained
    '{1'b1,1'b1,1'b0,1'b0,8'd0,1'b1, 1'b1,8'd0, 4'd7},
    '{1'b1,1'b0,1'b0,1'b0,8'd0,1'b1, 1'b1,8'd0, 4'd7},
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b1, 1'b0,8'd0, 4'd7},
    '{1'b0,1'b0,1'b0,1'b1,8'd0,1'b0, 1'b0,8'd0, 4'd10}, // R10 zero reload
    '{1'b1,1'b1,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd0, 4'd10},
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b1,8'd0, 4'd10},
    '{1'b0,1'b0,1'b0,1'b0,8'd0,1'b0, 1'b0,8'd0, 4'd10}
  };

  task automatic drive(input logic b, input logic s, input logic f,
                       input logic w, input logic [7:0] d, input logic x);
    @(negedge clk);
    beatStored = b; beatSeq = s; burstFull = f;
    reloadWrite = w; reloadData = d; combineDisable = x;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input int req, input logic expF, input logic [7:0] expT,
                       input logic expS);
    checks++;
    if (flushReq !== expF || timerValue !== expT || singleBeatMode !== expS) begin
      fails++;
      $display("FAIL R%0d: flush=%0b timer=%0d single=%0b, expected flush=%0b timer=%0d single=%0b",
               req, flushReq, timerValue, singleBeatMode, expF, expT, expS);
    end
  endtask

  initial begin
    rstN = 1'b0;
    drive(0, 0, 0, 0, 8'd0, 0);
    drive(0, 0, 0, 0, 8'd0, 0);
    check(1, 1'b0, 8'd0, 1'b0);  // R1 reset state
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].beat, VECS[i].seq, VECS[i].full, VECS[i].wr,
            VECS[i].data, VECS[i].dis);
      check(int'(VECS[i].req), VECS[i].expF, VECS[i].expT, VECS[i].dis);
    end

    // R1: reset again restores reload value 8 and clears outputs
    drive(1, 1, 0, 0, 8'd0, 0);
    rstN = 1'b0;
    drive(0, 0, 0, 0, 8'd0, 0);
    check(1, 1'b0, 8'd0, 1'b0);
    rstN = 1'b1;
    drive(1, 1, 0, 0, 8'd0, 0);
    check(1, 1'b0, 8'd8, 1'b0);
    // R6: equal value does not pull the count down
    drive(0, 0, 0, 1, 8'd8, 0);
    check(6, 1'b0, 8'd7, 1'b0);
    for (int k = 6; k >= 0; k--) begin
      drive(0, 0, 0, 0, 8'd0, 0);
      check(2, 1'b0, 8'(k), 1'b0);
    end
    drive(0, 0, 0, 0, 8'd0, 0);
    check(3, 1'b1, 8'd0, 1'b0);  // R3 expiry after full count of 8
    drive(0, 0, 0, 0, 8'd0, 0);
    check(3, 1'b0, 8'd0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule